// File: doc/BRIEF.md
# I/O Port Configuration Address Decoder

This block sits on the path of 16-bit I/O port accesses and decides where each one lands. One port holds a 32-bit configuration address register. A four-byte data window is steered by that register. When the register's enable bit is set, a window access becomes a configuration-space address built from the register's index bits and the low two port bits. When the enable bit is clear, the access goes to plain I/O space. Every other port goes straight to I/O space.

Each request is presented for one cycle with a strobe. The decode result appears on registered outputs one cycle later, with its own strobe: a space select, a target address and an uncacheable flag. A read of the register port also returns the register contents. A write to the register port changes the register on the same clock edge that captures the decode. The configuration bus and the data it returns are handled elsewhere.

Top module: `ioport_cfg_decoder`

## Requirements
- R1: After reset, rsp_valid is 0 and the configuration address register holds 0, so a 4-byte read of port 0xCF8 returns rsp_rdata = 0.
- R2: rsp_valid is 1 in exactly the cycle that follows a cycle with req_valid = 1, and is 0 otherwise.
- R3: A 4-byte write (req_size = 4, req_write = 1) to port 0xCF8 loads req_wdata into the register. Its response has rsp_space = 2 (register), rsp_addr = 0, rsp_uncached = 0 and rsp_rdata = 0.
- R4: A 4-byte read of port 0xCF8 gives rsp_space = 2, rsp_addr = 0, rsp_uncached = 0 and rsp_rdata equal to the register value, and leaves the register unchanged. Every access that is not such a read gives rsp_rdata = 0.
- R5: An access to port 0xCF8 whose size is not 4 gives rsp_space = 0 (I/O), rsp_addr = IO_PREFIX | port and rsp_uncached = 1, and leaves the register unchanged.
- R6: An access to ports 0xCFC to 0xCFF while register bit 31 is 1 gives rsp_space = 1 (configuration) and rsp_uncached = 1. Its address is rsp_addr = CFG_PREFIX | (register & 0x7FFFFFFC) | port[1:0]. The defaults are CFG_PREFIX = 0x80_0000_0000 and IO_PREFIX = 0x40_0000_0000. The access does not change the register.
- R7: An access to ports 0xCFC to 0xCFF while register bit 31 is 0 gives rsp_space = 0, rsp_addr = IO_PREFIX | port and rsp_uncached = 1.
- R8: An access to any port outside 0xCF8 and 0xCFC to 0xCFF gives rsp_space = 0, rsp_addr = IO_PREFIX | port and rsp_uncached = 1.
- R9: A data-window access in the cycle right after a register write is decoded with the newly written register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_port | input | 16 | I/O port number |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Decode result strobe, one cycle after req_valid |
| rsp_space | output | 2 | Target space: 0 I/O, 1 configuration, 2 internal register |
| rsp_addr | output | 40 | Target address |
| rsp_uncached | output | 1 | Access must bypass caches |
| rsp_rdata | output | 32 | Register contents for a 4-byte read of 0xCF8, else 0 |

## Verification
Two things can happen in the same cycle: the register update from a 4-byte write to 0xCF8, and the decode of a data-window access in the next cycle, which depends on that update. The bench provokes this with back-to-back requests with no idle cycle between them. Some are directed, where a write with bit 31 set is followed at once by a window access. Others come from random streams that often hit 0xCF8 and the window. Each response is compared against a bench model whose register copy changes only after the expected value of the current request has been computed. A decode that used a stale or early register value therefore shows up as a wrong space or address.

// File: rtl/ioc_pkg.sv
// Shared types for the I/O port configuration address decoder.
// Assumes: space codes are seen by downstream logic and must keep their values.
package ioc_pkg;
    typedef enum logic [1:0] {
        SPACE_IO  = 2'd0,
        SPACE_CFG = 2'd1,
        SPACE_REG = 2'd2
    } space_e;

    typedef enum logic [1:0] {
        KIND_OTHER    = 2'd0,
        KIND_ADDR_REG = 2'd1,
        KIND_WINDOW   = 2'd2
    } kind_e;
endpackage

// File: rtl/ioc_port_classify.sv
// Classifies one I/O access by port and size: the address register port
// (only at the exact register size), the four-byte data window, or anything else.
// Assumes: WIN_PORT is aligned to four bytes.
module ioc_port_classify
    import ioc_pkg::*;
#(
    parameter int          PORT_W   = 16,
    parameter int          SIZE_W   = 3,
    parameter logic [15:0] REG_PORT = 16'hCF8,
    parameter logic [15:0] WIN_PORT = 16'hCFC,
    parameter int          REG_SIZE = 4
) (
    input  logic [PORT_W-1:0] port,
    input  logic [SIZE_W-1:0] size,
    output kind_e             kind
);
    localparam logic [PORT_W-1:0] REG_P = REG_PORT[PORT_W-1:0];
    localparam logic [PORT_W-1:0] WIN_P = WIN_PORT[PORT_W-1:0];
    localparam logic [SIZE_W-1:0] REG_S = SIZE_W'(REG_SIZE);

    logic hit_reg;
    logic hit_win;

    // Match the register port at its exact size, and the window by ignoring the low two bits.
    always_comb begin
        hit_reg = (port == REG_P) && (size == REG_S);
        hit_win = (port[PORT_W-1:2] == WIN_P[PORT_W-1:2]);
    end

    // Pick the access kind; the two matches never overlap.
    always_comb begin
        if (hit_reg)      kind = KIND_ADDR_REG;
        else if (hit_win) kind = KIND_WINDOW;
        else              kind = KIND_OTHER;
    end
endmodule

// File: rtl/ioc_cfg_addr_reg.sv
// Configuration address register: loads on a qualified write, holds otherwise.
// Assumes: the caller has already qualified wr_en with port, size and direction.
module ioc_cfg_addr_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] q
);
    // Clear on reset, load on a qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wr_data;
    end
endmodule

// File: rtl/ioc_addr_build.sv
// Forms the target space, address and uncacheable flag for one access.
// The data window goes to configuration space when the register's top bit is set.
// Assumes: ADDR_W > DATA_W, and the prefixes have no bits below DATA_W.
module ioc_addr_build
    import ioc_pkg::*;
#(
    parameter int                ADDR_W     = 40,
    parameter int                PORT_W     = 16,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] IO_PREFIX  = 40'h40_0000_0000,
    parameter logic [ADDR_W-1:0] CFG_PREFIX = 40'h80_0000_0000
) (
    input  kind_e             kind,
    input  logic [PORT_W-1:0] port,
    input  logic [DATA_W-1:0] cfg_q,
    output space_e            space,
    output logic [ADDR_W-1:0] addr,
    output logic              uncached
);
    localparam int EN_BIT = DATA_W - 1;

    logic [ADDR_W-1:0] io_addr;
    logic [ADDR_W-1:0] cfg_addr;

    // Build both candidate addresses; the index bits keep their positions.
    always_comb begin
        io_addr  = IO_PREFIX | ADDR_W'(port);
        cfg_addr = CFG_PREFIX | ADDR_W'({cfg_q[DATA_W-2:2], port[1:0]});
    end

    // Choose the space and address by access kind and the enable bit.
    always_comb begin
        space    = SPACE_IO;
        addr     = io_addr;
        uncached = 1'b1;
        unique case (kind)
            KIND_ADDR_REG: begin
                space    = SPACE_REG;
                addr     = '0;
                uncached = 1'b0;
            end
            KIND_WINDOW: begin
                if (cfg_q[EN_BIT]) begin
                    space = SPACE_CFG;
                    addr  = cfg_addr;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ioport_cfg_decoder.sv
// Top level: decodes one I/O access per cycle and registers the result, which
// appears the cycle after the request strobe. A 4-byte write to the register
// port updates the register on the same edge.
// Assumes: one request at a most per cycle; req_size is a byte count.
module ioport_cfg_decoder
    import ioc_pkg::*;
#(
    parameter int                ADDR_W     = 40,
    parameter int                PORT_W     = 16,
    parameter int                SIZE_W     = 3,
    parameter int                DATA_W     = 32,
    parameter logic [15:0]       REG_PORT   = 16'hCF8,
    parameter logic [15:0]       WIN_PORT   = 16'hCFC,
    parameter int                REG_SIZE   = 4,
    parameter logic [ADDR_W-1:0] IO_PREFIX  = 40'h40_0000_0000,
    parameter logic [ADDR_W-1:0] CFG_PREFIX = 40'h80_0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PORT_W-1:0] req_port,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [1:0]        rsp_space,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_uncached,
    output logic [DATA_W-1:0] rsp_rdata
);
    kind_e             kind;
    space_e            nxt_space;
    logic [ADDR_W-1:0] nxt_addr;
    logic              nxt_unc;
    logic [DATA_W-1:0] cfg_q;
    logic              cfg_wr;
    logic [DATA_W-1:0] nxt_rdata;

    ioc_port_classify #(
        .PORT_W  (PORT_W),
        .SIZE_W  (SIZE_W),
        .REG_PORT(REG_PORT),
        .WIN_PORT(WIN_PORT),
        .REG_SIZE(REG_SIZE)
    ) u_classify (
        .port(req_port),
        .size(req_size),
        .kind(kind)
    );

    // Qualify the register write and select the read data.
    always_comb begin
        cfg_wr    = req_valid && req_write && (kind == KIND_ADDR_REG);
        nxt_rdata = (kind == KIND_ADDR_REG && !req_write) ? cfg_q : '0;
    end

    ioc_cfg_addr_reg #(
        .DATA_W(DATA_W)
    ) u_cfg_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr),
        .wr_data(req_wdata),
        .q      (cfg_q)
    );

    ioc_addr_build #(
        .ADDR_W    (ADDR_W),
        .PORT_W    (PORT_W),
        .DATA_W    (DATA_W),
        .IO_PREFIX (IO_PREFIX),
        .CFG_PREFIX(CFG_PREFIX)
    ) u_build (
        .kind    (kind),
        .port    (req_port),
        .cfg_q   (cfg_q),
        .space   (nxt_space),
        .addr    (nxt_addr),
        .uncached(nxt_unc)
    );

    // Response strobe: follows the request strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= req_valid;
    end

    // Response payload: captured with each request, held between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_space    <= SPACE_IO;
            rsp_addr     <= '0;
            rsp_uncached <= 1'b0;
            rsp_rdata    <= '0;
        end else if (req_valid) begin
            rsp_space    <= nxt_space;
            rsp_addr     <= nxt_addr;
            rsp_uncached <= nxt_unc;
            rsp_rdata    <= nxt_rdata;
        end
    end
endmodule

// File: rtl/ioc_decoder_chk.sv
// Checker for ioport_cfg_decoder, attached by bind below.
// Assumes: default parameters for port numbers and register size.
module ioc_decoder_chk
    import ioc_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int PORT_W = 16,
    parameter int SIZE_W = 3,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [PORT_W-1:0] req_port,
    input logic [SIZE_W-1:0] req_size,
    input logic              req_write,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic [1:0]        rsp_space,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic              rsp_uncached,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [DATA_W-1:0] cfg_q
);
    logic reg_wr_req;
    always_comb reg_wr_req = req_valid && req_write &&
                             (req_port == PORT_W'(16'hCF8)) && (req_size == SIZE_W'(4));

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R3
    reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_req |=> (cfg_q == $past(req_wdata)));
    // R4
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr_req |=> $stable(cfg_q));
    // R6
    cfg_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_space == SPACE_CFG) |->
            (rsp_uncached && rsp_addr[1:0] == $past(req_port[1:0])));
    // R3
    reg_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_space == SPACE_REG) |-> (!rsp_uncached && rsp_addr == '0));
    // R8
    io_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_space == SPACE_IO) |->
            (rsp_uncached && rsp_addr[PORT_W-1:0] == $past(req_port)));
    // R4
    rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_space != SPACE_REG) |-> (rsp_rdata == '0));
endmodule

bind ioport_cfg_decoder ioc_decoder_chk #(
    .ADDR_W(ADDR_W),
    .PORT_W(PORT_W),
    .SIZE_W(SIZE_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_port    (req_port),
    .req_size    (req_size),
    .req_write   (req_write),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_space   (rsp_space),
    .rsp_addr    (rsp_addr),
    .rsp_uncached(rsp_uncached),
    .rsp_rdata   (rsp_rdata),
    .cfg_q       (cfg_q)
);

// File: tb/ioport_cfg_decoder_test.sv
`timescale 1ns/1ps
module ioport_cfg_decoder_test;
    localparam logic [39:0] IO_PFX  = 40'h40_0000_0000;
    localparam logic [39:0] CFG_PFX = 40'h80_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_port = '0;
    logic [2:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_space;
    logic [39:0] rsp_addr;
    logic        rsp_uncached;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] model_reg = '0;

    always #10 clk = ~clk;

    ioport_cfg_decoder uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_space(rsp_space), .rsp_addr(rsp_addr),
        .rsp_uncached(rsp_uncached), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [15:0] p, input logic [2:0] s, input logic w);
        if (p == 16'hCF8 && s == 3'd4) return w ? "R3" : "R4";
        if (p == 16'hCF8) return "R5";
        if (p[15:2] == 14'h33F) return model_reg[31] ? "R6" : "R7";
        return "R8";
    endfunction

    // Issue one request at a falling edge; check its response at the next falling edge.
    task automatic issue(input logic [15:0] p, input logic [2:0] s, input logic w,
                         input logic [31:0] d);
        logic [1:0]  e_space;
        logic [39:0] e_addr;
        logic        e_unc;
        logic [31:0] e_rd;
        string       t;
        t = tag_of(p, s, w);
        if (p == 16'hCF8 && s == 3'd4) begin
            e_space = 2'd2; e_addr = '0; e_unc = 1'b0; e_rd = w ? 32'h0 : model_reg;
        end else if (p[15:2] == 14'h33F && model_reg[31]) begin
            e_space = 2'd1; e_unc = 1'b1; e_rd = '0;
            e_addr = CFG_PFX | 40'(model_reg & 32'h7FFF_FFFC) | 40'(p[1:0]);
        end else begin
            e_space = 2'd0; e_unc = 1'b1; e_rd = '0; e_addr = IO_PFX | 40'(p);
        end
        req_valid = 1'b1; req_port = p; req_size = s; req_write = w; req_wdata = d;
        if (p == 16'hCF8 && s == 3'd4 && w) model_reg = d;
        @(negedge clk);
        check({t, " R2 valid"}, 64'(rsp_valid), 64'd1);
        check({t, " space"}, 64'(rsp_space), 64'(e_space));
        check({t, " addr"}, 64'(rsp_addr), 64'(e_addr));
        check({t, " uncached"}, 64'(rsp_uncached), 64'(e_unc));
        check({t, " rdata"}, 64'(rsp_rdata), 64'(e_rd));
    endtask

    task automatic idle();
        req_valid = 1'b0;
        @(negedge clk);
        check("R2 idle valid", 64'(rsp_valid), 64'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset valid", 64'(rsp_valid), 64'd0);
        issue(16'hCF8, 3'd4, 1'b0, 32'h0);                 // R1: register reads zero
        // R3 then R9: window access right after the write, no gap
        issue(16'hCF8, 3'd4, 1'b1, 32'h8000_1234);
        issue(16'hCFF, 3'd1, 1'b0, 32'h0);                 // R6, R9
        issue(16'hCFC, 3'd4, 1'b1, 32'hDEAD_BEEF);         // R6, write does not touch register
        issue(16'hCF8, 3'd4, 1'b0, 32'h0);                 // R4 read back
        issue(16'hCF8, 3'd2, 1'b1, 32'h1111_1111);         // R5
        issue(16'hCF8, 3'd1, 1'b0, 32'h0);                 // R5
        issue(16'hCF8, 3'd4, 1'b0, 32'h0);                 // R5 register unchanged
        idle();
        issue(16'hCF8, 3'd4, 1'b1, 32'h7FFF_FFFF);         // R3
        issue(16'hCFD, 3'd2, 1'b0, 32'h0);                 // R7, R9
        issue(16'hCF7, 3'd4, 1'b0, 32'h0);                 // R8
        issue(16'hCF9, 3'd4, 1'b0, 32'h0);                 // R8
        issue(16'hFFFF, 3'd1, 1'b1, 32'h5);                // R8
        issue(16'h0000, 3'd1, 1'b0, 32'h0);                // R8
        issue(16'hCF8, 3'd4, 1'b1, 32'hFFFF_FFFF);         // R3
        issue(16'hCFE, 3'd1, 1'b0, 32'h0);                 // R6 top index bits
        idle();
        for (int i = 0; i < 800; i++) begin
            logic [15:0] p;
            logic [2:0]  s;
            int          r;
            r = int'($urandom % 8);
            if (r < 3)      p = 16'hCF8;
            else if (r < 6) p = 16'hCFC | 16'($urandom % 4);
            else            p = 16'($urandom);
            r = int'($urandom % 4);
            s = (r == 0) ? 3'd1 : (r == 1) ? 3'd2 : 3'd4;
            issue(p, s, 1'($urandom), $urandom);
            if ($urandom % 4 == 0) idle();
        end
        idle();
        finish_run();
    end
endmodule